// File: doc/BRIEF.md
# Serial Divider-Control Word Loader

This block accepts control words for a frequency synthesizer's two programmable dividers over a three-line serial port: a bit clock, a data line and a load strobe. It samples all three lines in the system clock domain and shifts data bits in, most significant bit first. When the load strobe rises, it copies the word into one of two holding registers. The last bit shifted in chooses the destination. One holding register keeps the reference divider count together with three control flags: prescale select, lock-output enable and test. The other keeps the main divider count.

A width-select input sets the word length. When it is high the block uses narrow words: 17 serial bits and 16-bit payloads, with a 13-bit reference count. When it is low the block uses wide words: 19 serial bits and 18-bit payloads, with a 15-bit reference count. A standby input marks the divider section as powered down. The held values are not touched by standby, so they are valid again when the dividers wake. The serial port stays usable during standby.

Top module: `synth_serial_loader`

## Requirements
- R1: While reset is high, and on the first clock after it, every count and flag output and `div_active_o` are zero.
- R2: One data bit enters per rising edge of `ser_clk_i`, most significant bit first. Holding `ser_clk_i` high for many clocks still enters only one bit.
- R3: On a rising edge of `ser_le_i`, if the last bit shifted in is 1, the reference count and its three flags are loaded and the main count is left unchanged.
- R4: On a rising edge of `ser_le_i`, if the last bit shifted in is 0, the main count is loaded and the reference count and flags are left unchanged.
- R5: With `narrow_sel_i` high, the word is 17 bits. In sending order it is test, lock-enable, prescale select, then a 13-bit reference count (MSB first), then the select bit; for the main register it is a 16-bit count and then the select bit. The upper two bits of `ref_count_o` read zero after a narrow reference load.
- R6: With `narrow_sel_i` low, the word is 19 bits, laid out as in R5 but with a 15-bit reference count or an 18-bit main count.
- R7: Bits shifted in before the last 17 (narrow mode) or 19 (wide mode) have no effect on the loaded values.
- R8: `div_active_o` follows `stby_n_i`. Lowering `stby_n_i` and raising it again leaves all held values unchanged.
- R9: Every serial input reaches the outputs exactly two clocks after it is first sampled. The outputs change on the third rising clock edge after the input edge.
- R10: Shifting bits without a load-strobe edge does not change any held value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial bit clock from the controller |
| ser_data_i | input | 1 | Serial data, MSB first |
| ser_le_i | input | 1 | Load strobe; rising edge copies the word |
| narrow_sel_i | input | 1 | 1 = 17-bit words, 0 = 19-bit words |
| stby_n_i | input | 1 | Low = divider section in standby |
| ref_count_o | output | 15 | Held reference divider count |
| ref_prescale_o | output | 1 | Held prescale-select flag |
| ref_lock_en_o | output | 1 | Held lock-output enable flag |
| ref_test_o | output | 1 | Held test flag |
| main_count_o | output | 18 | Held main divider count |
| div_active_o | output | 1 | Divider section powered (synchronised `stby_n_i`) |

## Verification
The assertions assume two things. First, a rising bit-clock edge and a rising load-strobe edge never reach the shifter in the same system clock. Second, every serial level lasts at least one system clock, so no edge is lost in the synchronizer. The stimulus meets both. It holds each bit-clock and strobe level for two or more clocks and sets the data line before raising the bit clock. It never raises the strobe while bit clocking is in progress. It changes the width select only between words, and it waits for the synchronizer to settle before sending the next word.

// File: rtl/synth_loader_pkg.sv
package synth_loader_pkg;
  // bit positions of the synchronised control vector
  localparam int CTL_SCLK  = 0;
  localparam int CTL_DATA  = 1;
  localparam int CTL_LE    = 2;
  localparam int CTL_NAR   = 3;
  localparam int CTL_STBY  = 4;
  localparam int CTL_W     = 5;
  // three flag bits sit above the reference count
  localparam int FLAG_BITS = 3;

  function automatic int ref_cnt_width(input int payload_w);
    return payload_w - FLAG_BITS;
  endfunction
endpackage

// File: rtl/synth_loader_sync.sv
module synth_loader_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/synth_loader_shifter.sv
module synth_loader_shifter #(
  parameter int SR_W = 19
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sclk_s,
  input  logic            data_s,
  input  logic            le_s,
  output logic [SR_W-1:0] sr_q,
  output logic            load_o
);
  logic sclk_prev, le_prev, bit_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev <= 1'b0;
      le_prev   <= 1'b0;
    end else begin
      sclk_prev <= sclk_s;
      le_prev   <= le_s;
    end
  end

  assign bit_rise = sclk_s & ~sclk_prev;
  assign load_o   = le_s & ~le_prev;

  always_ff @(posedge clk) begin
    if (rst)           sr_q <= '0;
    else if (bit_rise) sr_q <= {sr_q[SR_W-2:0], data_s};
  end

  // R2: without a bit-clock edge the register holds
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !bit_rise |=> $stable(sr_q));
  // R2: bit-clock and strobe edges never coincide (input protocol)
  a_r2_edges_apart: assert property (@(posedge clk) disable iff (rst)
    !(bit_rise && load_o));
endmodule

// File: rtl/synth_loader_latches.sv
module synth_loader_latches
  import synth_loader_pkg::*;
#(
  parameter int NARROW_W = 16,
  parameter int WIDE_W   = 18
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load_i,
  input  logic                narrow_i,
  input  logic [WIDE_W:0]     sr_i,
  output logic [WIDE_W-4:0]   ref_cnt_o,
  output logic                prescale_o,
  output logic                lock_en_o,
  output logic                test_o,
  output logic [WIDE_W-1:0]   main_cnt_o
);
  localparam int RW_N = ref_cnt_width(NARROW_W);
  localparam int RW_W = ref_cnt_width(WIDE_W);
  localparam int EXT  = RW_W - RW_N;
  localparam int MEXT = WIDE_W - NARROW_W;

  logic              sel_ref;
  logic [RW_W-1:0]   cnt_dec;
  logic [2:0]        flag_dec;   // {test, lock_en, prescale}
  logic [WIDE_W-1:0] main_dec;

  assign sel_ref = sr_i[0];

  always_comb begin
    if (narrow_i) begin
      cnt_dec  = {{EXT{1'b0}}, sr_i[RW_N:1]};
      flag_dec = sr_i[RW_N+3:RW_N+1];
      main_dec = {{MEXT{1'b0}}, sr_i[NARROW_W:1]};
    end else begin
      cnt_dec  = sr_i[RW_W:1];
      flag_dec = sr_i[RW_W+3:RW_W+1];
      main_dec = sr_i[WIDE_W:1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_cnt_o  <= '0;
      prescale_o <= 1'b0;
      lock_en_o  <= 1'b0;
      test_o     <= 1'b0;
    end else if (load_i && sel_ref) begin
      ref_cnt_o  <= cnt_dec;
      prescale_o <= flag_dec[0];
      lock_en_o  <= flag_dec[1];
      test_o     <= flag_dec[2];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                   main_cnt_o <= '0;
    else if (load_i && !sel_ref) main_cnt_o <= main_dec;
  end

  // R3: a reference load leaves the main count alone
  a_r3_main_kept: assert property (@(posedge clk) disable iff (rst)
    load_i && sel_ref |=> $stable(main_cnt_o));
  // R4: a main load leaves the reference side alone
  a_r4_ref_kept: assert property (@(posedge clk) disable iff (rst)
    load_i && !sel_ref |=> $stable(ref_cnt_o) && $stable({test_o, lock_en_o, prescale_o}));
  // R5: narrow reference load clears the unused count bits
  a_r5_narrow_top_zero: assert property (@(posedge clk) disable iff (rst)
    load_i && sel_ref && narrow_i |=> ref_cnt_o[RW_W-1:RW_N] == '0);
  // R10: no strobe edge, no change
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(ref_cnt_o) && $stable(main_cnt_o)
                && $stable({test_o, lock_en_o, prescale_o}));
endmodule

// File: rtl/synth_serial_loader.sv
module synth_serial_loader
  import synth_loader_pkg::*;
#(
  parameter int NARROW_W    = 16,
  parameter int WIDE_W      = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk_i,
  input  logic              ser_data_i,
  input  logic              ser_le_i,
  input  logic              narrow_sel_i,
  input  logic              stby_n_i,
  output logic [WIDE_W-4:0] ref_count_o,
  output logic              ref_prescale_o,
  output logic              ref_lock_en_o,
  output logic              ref_test_o,
  output logic [WIDE_W-1:0] main_count_o,
  output logic              div_active_o
);
  localparam int SR_W = WIDE_W + 1;

  logic [CTL_W-1:0] ctl_raw, ctl_s;
  logic [SR_W-1:0]  sr;
  logic             load;

  always_comb begin
    ctl_raw           = '0;
    ctl_raw[CTL_SCLK] = ser_clk_i;
    ctl_raw[CTL_DATA] = ser_data_i;
    ctl_raw[CTL_LE]   = ser_le_i;
    ctl_raw[CTL_NAR]  = narrow_sel_i;
    ctl_raw[CTL_STBY] = stby_n_i;
  end

  synth_loader_sync #(.W(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .d_i (ctl_raw), .q_o (ctl_s)
  );

  synth_loader_shifter #(.SR_W(SR_W)) u_shift (
    .clk    (clk),
    .rst    (rst),
    .sclk_s (ctl_s[CTL_SCLK]),
    .data_s (ctl_s[CTL_DATA]),
    .le_s   (ctl_s[CTL_LE]),
    .sr_q   (sr),
    .load_o (load)
  );

  synth_loader_latches #(.NARROW_W(NARROW_W), .WIDE_W(WIDE_W)) u_latch (
    .clk        (clk),
    .rst        (rst),
    .load_i     (load),
    .narrow_i   (ctl_s[CTL_NAR]),
    .sr_i       (sr),
    .ref_cnt_o  (ref_count_o),
    .prescale_o (ref_prescale_o),
    .lock_en_o  (ref_lock_en_o),
    .test_o     (ref_test_o),
    .main_cnt_o (main_count_o)
  );

  always_ff @(posedge clk) begin
    if (rst) div_active_o <= 1'b0;
    else     div_active_o <= ctl_s[CTL_STBY];
  end

  // R1: reset clears every output
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (ref_count_o == '0 && main_count_o == '0 && !div_active_o
             && !ref_prescale_o && !ref_lock_en_o && !ref_test_o));
  // R8: while in standby with no load, held counts do not move
  a_r8_standby_retains: assert property (@(posedge clk) disable iff (rst)
    !div_active_o && !load |=> $stable(ref_count_o) && $stable(main_count_o));
endmodule

// File: tb/synth_serial_loader_tb_top.sv
module synth_serial_loader_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0, sdata = 1'b0, sle = 1'b0, nsel = 1'b1, stby_n = 1'b0;
  logic [14:0] ref_cnt;
  logic        pre, lck, tst, act;
  logic [17:0] main_cnt;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #10 clk = ~clk;

  synth_serial_loader dut_i (
    .clk (clk), .rst (rst),
    .ser_clk_i (sclk), .ser_data_i (sdata), .ser_le_i (sle),
    .narrow_sel_i (nsel), .stby_n_i (stby_n),
    .ref_count_o (ref_cnt), .ref_prescale_o (pre), .ref_lock_en_o (lck),
    .ref_test_o (tst), .main_count_o (main_cnt), .div_active_o (act)
  );

  // ---------------- behavioural reference model ----------------
  logic [4:0]  inq [$];   // {stby, narrow, le, data, sclk}
  logic [4:0]  d, dp;
  logic [18:0] m_sr;
  logic [14:0] m_rc;
  logic [17:0] m_mc;
  logic        m_pre, m_lck, m_tst, m_act;

  always @(posedge clk) begin
    if (rst) begin
      inq.delete();
      dp = '0; m_sr = '0; m_rc = '0; m_mc = '0;
      m_pre = 0; m_lck = 0; m_tst = 0; m_act = 0;
    end else begin
      inq.push_back({stby_n, nsel, sle, sdata, sclk});
      if (inq.size() > 2) d = inq.pop_front();
      else d = '0;
      if (d[2] && !dp[2]) begin
        int rw;
        rw = d[3] ? 13 : 15;
        if (m_sr[0]) begin
          m_rc  = 15'((m_sr >> 1) & ((19'd1 << rw) - 19'd1));
          m_pre = m_sr[rw+1];
          m_lck = m_sr[rw+2];
          m_tst = m_sr[rw+3];
        end else begin
          m_mc = 18'((m_sr >> 1) & ((19'd1 << (d[3] ? 16 : 18)) - 19'd1));
        end
      end
      if (d[0] && !dp[0]) m_sr = {m_sr[17:0], d[1]};
      m_act = d[4];
      dp = d;
    end
  end

  // R9: every clock, outputs equal the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      n_checks++;
      if ({ref_cnt, pre, lck, tst, main_cnt, act} !==
          {m_rc, m_pre, m_lck, m_tst, m_mc, m_act}) begin
        n_fail++;
        $display("FAIL R9 cycle model: actual rc=%h f=%b%b%b mc=%h a=%b expected rc=%h f=%b%b%b mc=%h a=%b",
                 ref_cnt, pre, lck, tst, main_cnt, act,
                 m_rc, m_pre, m_lck, m_tst, m_mc, m_act);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] w, input int len, input int hi);
    for (int i = len - 1; i >= 0; i--) begin
      sdata = w[i];
      tick(2);
      sclk = 1'b1;
      tick(hi);
      sclk = 1'b0;
      tick(2);
    end
  endtask

  task automatic strobe();
    sle = 1'b1; tick(3);
    sle = 1'b0; tick(4);
  endtask

  task automatic chk(input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
    n_checks++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act_v, exp_v);
    end
  endtask

  function automatic logic [31:0] ref_word(input bit narrow, input logic [14:0] c,
                                           input bit f, input bit l, input bit t);
    if (narrow) return {13'd0, t, l, f, c[12:0], 1'b1};
    else        return {11'd0, t, l, f, c, 1'b1};
  endfunction

  // ---------------- sequence ----------------
  initial begin
    tick(5);
    // R1: reset state
    chk("R1 ref_count", {17'd0, ref_cnt}, 0);
    chk("R1 main_count", {14'd0, main_cnt}, 0);
    chk("R1 flags/active", {28'd0, pre, lck, tst, act}, 0);
    rst = 1'b0;
    stby_n = 1'b1;
    tick(1);
    chk("R1 after release", {14'd0, main_cnt}, 0);
    tick(4);
    chk("R8 active high", {31'd0, act}, 1);

    // R3 R5: narrow reference load
    send_bits(ref_word(1, 15'h1ABC, 1, 0, 1), 17, 3);
    strobe();
    chk("R3/R5 ref count narrow", {17'd0, ref_cnt}, 32'h1ABC);
    chk("R3/R5 flags {pre,lck,tst}", {29'd0, pre, lck, tst}, 32'b101);
    chk("R3 main untouched", {14'd0, main_cnt}, 0);

    // R4 R2: narrow main load, bit clock held high long
    send_bits({15'd0, 16'hBEEF, 1'b0}, 17, 8);
    strobe();
    chk("R4/R2 main narrow", {14'd0, main_cnt}, 32'hBEEF);
    chk("R4 ref untouched", {17'd0, ref_cnt}, 32'h1ABC);

    // R10: shift without strobe
    send_bits({15'd0, 16'h5555, 1'b0}, 17, 3);
    tick(4);
    chk("R10 main held", {14'd0, main_cnt}, 32'hBEEF);

    // R7: extra leading bits dropped
    send_bits({12'd0, 3'b111, 16'h1234, 1'b0}, 20, 3);
    strobe();
    chk("R7 main after extra bits", {14'd0, main_cnt}, 32'h1234);

    // R6: wide mode
    nsel = 1'b0; tick(4);
    send_bits(ref_word(0, 15'h5A5A, 0, 1, 0), 19, 3);
    strobe();
    chk("R6 ref count wide", {17'd0, ref_cnt}, 32'h5A5A);
    chk("R6 flags {pre,lck,tst}", {29'd0, pre, lck, tst}, 32'b010);
    send_bits({13'd0, 18'h2B3C4, 1'b0}, 19, 3);
    strobe();
    chk("R6 main wide", {14'd0, main_cnt}, 32'h2B3C4);

    // R8: standby retention
    stby_n = 1'b0; tick(4);
    chk("R8 active low", {31'd0, act}, 0);
    chk("R8 main retained", {14'd0, main_cnt}, 32'h2B3C4);
    stby_n = 1'b1; tick(4);
    chk("R8 active again", {31'd0, act}, 1);
    chk("R8 ref retained", {17'd0, ref_cnt}, 32'h5A5A);

    // R5: narrow load after wide clears the upper count bits
    nsel = 1'b1; tick(4);
    send_bits(ref_word(1, 15'h0003, 0, 0, 0), 17, 3);
    strobe();
    chk("R5 narrow upper bits cleared", {17'd0, ref_cnt}, 32'h0003);
    chk("R5 main kept", {14'd0, main_cnt}, 32'h2B3C4);

    // R4: all-ones wide main
    nsel = 1'b0; tick(4);
    send_bits({13'd0, 18'h3FFFF, 1'b0}, 19, 3);
    strobe();
    chk("R4 main all ones", {14'd0, main_cnt}, 32'h3FFFF);
    chk("R4 ref kept", {17'd0, ref_cnt}, 32'h0003);

    tick(5);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule